// File: doc/BRIEF.md
# Serial Interrupt Request Message Transmitter

This block turns one interrupt delivery request into a fixed-length frame on a two-wire serial interrupt bus. A request carries an arbitration ID, a destination mode flag, a 3-bit delivery mode, level and trigger-mode flags, an 8-bit vector and an 8-bit destination. The block moves two bits onto the bus in each cycle. The delivery mode is an opaque code, and the block gives no meaning to any of its values.

A frame lasts 21 bus cycles and has this layout:

| Frame cycle | Content on busDrive[1:0] |
|---|---|
| 1 | type code `01` |
| 2 to 5 | arbitration ID, most significant bit first, on bit 1; bit 0 is `0` |
| 6 to 8 | control fields |
| 9 to 12 | vector |
| 13 to 16 | destination |
| 17 | checksum |
| 18 | gap, `00` |
| 19 and 20 | status cycles; the outputs are released and the bus is sampled |
| 21 | idle, `00` |

During cycle 21 the block pulses `done` and reports whether any receiver flagged a checksum error. Arbitration loss and resending are left to the logic that uses the block.

Top module: `irq_msg_tx`

## Requirements
- R1: After reset the block is idle. reqReady is 1, while busDriveEn, done and busDrive are all 0.
- R2: A request is accepted only on a clock edge where reqValid and reqReady are both 1. If reqValid is raised during a frame, that frame is unchanged and no second frame starts from it.
- R3: Frame cycle 1 drives 01. Frame cycles 2 to 5 drive {arbId[3-k], 0} for k = 0 to 3.
- R4: Frame cycle 6 drives {destMode, delivMode[2]}. Cycle 7 drives delivMode[1:0]. Cycle 8 drives {levelFlag, trigMode}.
- R5: Frame cycles 9 to 12 drive vector[7:6], vector[5:4], vector[3:2] and vector[1:0], in that order.
- R6: Frame cycles 13 to 16 drive destId[7:6], destId[5:4], destId[3:2] and destId[1:0], in that order.
- R7: Frame cycle 17 drives a 2-bit checksum of the 11 pairs sent in cycles 6 to 16, taken in order. A running 2-bit sum starts at 0 and each pair is added to it. After every addition except the last, the carry out is added back into the sum. After the last addition the carry is dropped.
- R8: In frame cycles 1 to 18 and in cycle 21, busDriveEn is 1. Cycles 18 and 21 drive 00. In cycles 19 and 20, busDriveEn is 0 and busDrive is 00.
- R9: done is 1 only during frame cycle 21. ok is 1 then unless busSense read 11 during frame cycle 19.
- R10: Frame cycle 1 starts in the cycle after the accepting edge, and a frame lasts exactly 21 cycles. reqReady is 0 throughout the frame and is 1 again in the cycle after cycle 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present |
| reqReady | output | 1 | The block is idle and will take a request |
| destMode | input | 1 | Destination mode flag |
| delivMode | input | 3 | Delivery mode code, treated as opaque |
| levelFlag | input | 1 | Level flag |
| trigMode | input | 1 | Trigger mode flag |
| vector | input | 8 | Interrupt vector |
| arbId | input | 4 | Arbitration ID |
| destId | input | 8 | Destination field |
| busDrive | output | 2 | Bit pair driven onto the bus |
| busDriveEn | output | 1 | Output enable for busDrive |
| busSense | input | 2 | Bus value as seen by the block |
| done | output | 1 | One-cycle pulse in frame cycle 21 |
| ok | output | 1 | No checksum error was reported; valid while done is 1 |

## Verification
The assertions assume that reqValid and the request fields are stable at the clock edge where they are sampled. They also assume busSense is meaningful only during the released status cycles. The bench drives every input and busSense on the falling edge and drives busSense away from 00 only during the status cycles. A sweep covers all 64 combinations of the destination mode, delivery mode, level flag and trigger flag. Each combination gets its own vector, destination and arbitration ID, and the status value it returns cycles through every code, including the error code. Some frames also carry a request raised while the block is busy.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int ARB_W  = 4;
  localparam int MODE_W = 3;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;

  // frame slot indices (slot 0 is frame cycle 1)
  localparam int S_TYPE  = 0;
  localparam int S_ARB   = S_TYPE + 1;
  localparam int S_CTRL  = S_ARB + ARB_W;
  localparam int S_VEC   = S_CTRL + 3;
  localparam int S_DEST  = S_VEC + VEC_W / 2;
  localparam int S_CHK   = S_DEST + DEST_W / 2;
  localparam int S_GAP   = S_CHK + 1;
  localparam int S_STAT0 = S_GAP + 1;
  localparam int S_STAT1 = S_STAT0 + 1;
  localparam int S_IDLE  = S_STAT1 + 1;
  localparam int FRAME_LEN = S_IDLE + 1;
  localparam int SLOT_W  = $clog2(FRAME_LEN);

  // pairs covered by the checksum: control pairs, vector, destination
  localparam int CK_BITS  = 1 + MODE_W + 2 + VEC_W + DEST_W;
  localparam int CK_PAIRS = CK_BITS / 2;

  typedef struct packed {
    logic              load;
    logic              drive;
    logic              sample;
    logic              done;
    logic [SLOT_W-1:0] slot;
  } ctrl_t;
endpackage

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  output logic  reqReady,
  output ctrl_t ctl
);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(S_IDLE);
  localparam logic [SLOT_W-1:0] STAT0 = SLOT_W'(S_STAT0);
  localparam logic [SLOT_W-1:0] STAT1 = SLOT_W'(S_STAT1);

  logic              busy;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (!busy) begin
      if (reqValid) begin
        busy <= 1'b1;
        slot <= '0;
      end
    end else if (slot == LAST) begin
      busy <= 1'b0;
      slot <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  assign reqReady = !busy;

  always_comb begin
    ctl.load   = !busy && reqValid;
    ctl.drive  = busy && (slot != STAT0) && (slot != STAT1);
    ctl.sample = busy && (slot == STAT0);
    ctl.done   = busy && (slot == LAST);
    ctl.slot   = slot;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && ctl.slot == '0));

  p_advance_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && ctl.slot != LAST) |=> (!reqReady && ctl.slot == $past(ctl.slot) + 1'b1));

  p_frame_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> reqReady);

  p_status_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sample |-> !ctl.drive);
endmodule

// File: rtl/irq_msg_dp.sv
module irq_msg_dp
  import irq_msg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic              destMode,
  input  logic [MODE_W-1:0] delivMode,
  input  logic              levelFlag,
  input  logic              trigMode,
  input  logic [VEC_W-1:0]  vector,
  input  logic [ARB_W-1:0]  arbId,
  input  logic [DEST_W-1:0] destId,
  input  logic [1:0]        busSense,
  output logic [1:0]        busDrive,
  output logic              busDriveEn,
  output logic              done,
  output logic              ok
);
  logic              dmR, lvR, tmR;
  logic [MODE_W-1:0] modeR;
  logic [VEC_W-1:0]  vecR;
  logic [ARB_W-1:0]  arbR;
  logic [DEST_W-1:0] destR;
  logic [1:0]        statR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmR <= 1'b0; lvR <= 1'b0; tmR <= 1'b0;
      modeR <= '0; vecR <= '0; arbR <= '0; destR <= '0;
      statR <= 2'b00;
    end else begin
      if (ctl.load) begin
        dmR   <= destMode;
        modeR <= delivMode;
        lvR   <= levelFlag;
        tmR   <= trigMode;
        vecR  <= vector;
        arbR  <= arbId;
        destR <= destId;
      end
      if (ctl.sample) statR <= busSense;
    end
  end

  // bit pairs for each data slot
  logic [1:0] frame [FRAME_LEN];
  assign frame[S_TYPE] = 2'b01;
  genvar gi;
  generate
    for (gi = 0; gi < ARB_W; gi++) begin : g_arb
      assign frame[S_ARB + gi] = {arbR[ARB_W-1-gi], 1'b0};
    end
    for (gi = 0; gi < VEC_W / 2; gi++) begin : g_vec
      assign frame[S_VEC + gi] = vecR[VEC_W-1-2*gi -: 2];
    end
    for (gi = 0; gi < DEST_W / 2; gi++) begin : g_dest
      assign frame[S_DEST + gi] = destR[DEST_W-1-2*gi -: 2];
    end
  endgenerate
  assign frame[S_CTRL]     = {dmR, modeR[2]};
  assign frame[S_CTRL + 1] = modeR[1:0];
  assign frame[S_CTRL + 2] = {lvR, tmR};
  assign frame[S_GAP]      = 2'b00;
  assign frame[S_STAT0]    = 2'b00;
  assign frame[S_STAT1]    = 2'b00;
  assign frame[S_IDLE]     = 2'b00;

  // checksum: fold carries back in except after the final addition
  logic [CK_BITS-1:0] ckBits;
  logic [1:0]         csum;
  assign ckBits = {dmR, modeR, lvR, tmR, vecR, destR};
  always_comb begin
    logic [2:0] s;
    csum = 2'b00;
    for (int k = 0; k < CK_PAIRS; k++) begin
      s = {1'b0, csum} + {1'b0, ckBits[2*(CK_PAIRS-1-k) +: 2]};
      if (k < CK_PAIRS - 1) csum = s[1:0] + {1'b0, s[2]};
      else                  csum = s[1:0];
    end
  end
  assign frame[S_CHK] = csum;

  assign busDriveEn = ctl.drive;
  assign busDrive   = ctl.drive ? frame[ctl.slot] : 2'b00;
  assign done       = ctl.done;
  assign ok         = (statR != 2'b11);

  p_hold_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(vecR) && $stable(arbR) && $stable(destR) && $stable(modeR)));

  p_type_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.drive && ctl.slot == SLOT_W'(S_TYPE)) |-> busDrive == 2'b01);

  p_quiet_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busDriveEn |-> busDrive == 2'b00);

  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sample && busSense == 2'b11) |=> !ok);
endmodule

// File: rtl/irq_msg_tx.sv
module irq_msg_tx
  import irq_msg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        destMode,
  input  logic [2:0]  delivMode,
  input  logic        levelFlag,
  input  logic        trigMode,
  input  logic [7:0]  vector,
  input  logic [3:0]  arbId,
  input  logic [7:0]  destId,
  output logic [1:0]  busDrive,
  output logic        busDriveEn,
  input  logic [1:0]  busSense,
  output logic        done,
  output logic        ok
);
  ctrl_t ctl;

  irq_msg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .ctl(ctl)
  );

  irq_msg_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .destMode(destMode), .delivMode(delivMode), .levelFlag(levelFlag),
    .trigMode(trigMode), .vector(vector), .arbId(arbId), .destId(destId),
    .busSense(busSense), .busDrive(busDrive), .busDriveEn(busDriveEn),
    .done(done), .ok(ok)
  );

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: tb/irq_msg_tx_tb.sv
module irq_msg_tx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic destMode = 1'b0, levelFlag = 1'b0, trigMode = 1'b0;
  logic [2:0] delivMode = '0;
  logic [7:0] vector = '0, destId = '0;
  logic [3:0] arbId = '0;
  logic [1:0] busDrive, busSense = 2'b00;
  logic busDriveEn, done, ok;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_msg_tx dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .destMode(destMode), .delivMode(delivMode), .levelFlag(levelFlag),
    .trigMode(trigMode), .vector(vector), .arbId(arbId), .destId(destId),
    .busDrive(busDrive), .busDriveEn(busDriveEn), .busSense(busSense),
    .done(done), .ok(ok)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] ckSum(input logic [21:0] bits);
    int acc = 0;
    for (int k = 0; k < 11; k++) begin
      acc = acc + ((bits >> (2 * (10 - k))) & 22'd3);
      if (k < 10) acc = (acc % 4) + (acc / 4);
      else acc = acc % 4;
    end
    return 2'(acc);
  endfunction

  function automatic logic [1:0] expPair(input int s, input logic dm, input logic [2:0] md,
      input logic lv, input logic tm, input logic [7:0] v, input logic [3:0] a, input logic [7:0] d);
    if (s == 0) return 2'b01;
    if (s >= 1 && s <= 4) return {a[4 - s], 1'b0};
    if (s == 5) return {dm, md[2]};
    if (s == 6) return md[1:0];
    if (s == 7) return {lv, tm};
    if (s >= 8 && s <= 11) return 2'((v >> (2 * (11 - s))) & 8'd3);
    if (s >= 12 && s <= 15) return 2'((d >> (2 * (15 - s))) & 8'd3);
    if (s == 16) return ckSum({dm, md, lv, tm, v, d});
    return 2'b00;
  endfunction

  function automatic string slotReq(input int s);
    if (s <= 4) return "R3";
    if (s <= 7) return "R4";
    if (s <= 11) return "R5";
    if (s <= 15) return "R6";
    if (s == 16) return "R7";
    return "R8";
  endfunction

  task automatic runFrame(input logic dm, input logic [2:0] md, input logic lv, input logic tm,
      input logic [7:0] v, input logic [3:0] a, input logic [7:0] d, input logic [1:0] st,
      input bit intrude);
    logic [1:0] ep;
    bit expEn;
    destMode = dm; delivMode = md; levelFlag = lv; trigMode = tm;
    vector = v; arbId = a; destId = d; reqValid = 1'b1;
    chk(reqReady == 1'b1, "R10 ready before request", reqReady, 1);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    for (int s = 0; s < 21; s++) begin
      ep = expPair(s, dm, md, lv, tm, v, a, d);
      expEn = !(s == 18 || s == 19);
      chk(busDriveEn == expEn, "R8 enable", busDriveEn, expEn);
      chk(busDrive == ep, slotReq(s), busDrive, ep);
      chk(reqReady == 1'b0, "R10 busy in frame", reqReady, 0);
      chk(done == (s == 20), "R9 done timing", done, (s == 20));
      if (s == 20) chk(ok == (st != 2'b11), "R9 ok flag", ok, (st != 2'b11));
      if (s == 18) busSense = st;
      else if (s == 19) busSense = 2'b10;
      else busSense = 2'b00;
      if (intrude && s == 4) begin
        // R2: request raised while busy; different fields
        reqValid = 1'b1; vector = ~v; arbId = ~a; destId = ~d; delivMode = ~md;
      end
      if (intrude && s == 6) reqValid = 1'b0;
      @(negedge clk);
    end
    chk(reqReady == 1'b1, "R10 ready after frame", reqReady, 1);
    chk(busDriveEn == 1'b0 && done == 1'b0, "R2 no second frame", busDriveEn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready", reqReady, 1);
    chk(busDriveEn == 1'b0, "R1 enable", busDriveEn, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(busDrive == 2'b00, "R1 drive", busDrive, 0);
    for (int c = 0; c < 64; c++) begin
      runFrame(c[5], c[4:2], c[1], c[0], 8'((c * 37 + 5) & 255), 4'((c * 7 + 3) & 15),
               8'((c * 91 + 17) & 255), 2'(c & 3), (c % 8) == 3);
      repeat (c % 3) @(negedge clk);
    end
    runFrame(1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 4'h0, 8'h00, 2'b00, 1'b0);
    runFrame(1'b1, 3'd7, 1'b1, 1'b1, 8'hFF, 4'hF, 8'hFF, 2'b11, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule